// File: doc/BRIEF.md
# Multi-channel latching event counter bank

This block holds a bank of independent event counters, one per input channel. Each channel's input is a synchronous, single-cycle pulse marking a leading edge, and the channel's counter advances by one for every such pulse. A trigger strobe copies every counter into its own shadow latch in the same clock cycle. Counting carries on through the capture without losing a pulse, so the latched snapshot is consistent across all channels.

A shared auxiliary gate input has a two-bit mode. The mode turns the gate into a counting inhibit, a reset of the whole bank, or a test pulse that every channel counts in parallel. The fourth mode code gives the gate no effect. An auto-reset option clears each counter with the trigger that latches it, so successive snapshots hold the counts of each interval between triggers. A software clear wipes the bank. A host read port returns any live counter value by byte address without disturbing counting.

Top module: `scaler_bank`

## Requirements
- R1: In a cycle with no clear, no inhibit and no auto-reset trigger, a channel's counter rises by exactly one when its `ch_pulse` bit is 1 and keeps its value when the bit is 0.
- R2: When `trig` is 1 and no clear is active, every latch takes the counter value held before that clock edge, in the same cycle. Counting proceeds in that cycle as if no trigger were present. With no trigger and no clear, the latches hold their values.
- R3: With `aux_mode` = 2'b00 and `aux_gate` = 1, no counter changes in that cycle, whatever `ch_pulse` carries.
- R4: With `aux_mode` = 2'b01 and `aux_gate` = 1, all counters and all latches become 0 after that edge.
- R5: With `aux_mode` = 2'b10 and `aux_gate` = 1, every channel counts one in that cycle. A channel whose own pulse is also 1 still counts only one.
- R6: With `aux_mode` = 2'b11, `aux_gate` has no effect on counting, latching or clearing.
- R7: With `auto_rst` = 1, a trigger clears every counter as it latches it. The latches therefore hold the count since the previous trigger.
- R8: When an auto-reset trigger coincides with a channel pulse, the latch receives the count before the reset, and the counter restarts at 1.
- R9: `sw_clr` = 1 sets all counters and all latches to 0 after that edge. It wins over any trigger or pulse in the same cycle.
- R10: `rd_data` presents, one cycle after `rd_addr`, the live value of channel N when `rd_addr` = 0x100 + 4*N for N < NCH. Any other address, whether misaligned, below 0x100 or past the last channel, reads 0.
- R11: A counter at all ones wraps to 0 on the next counted pulse, with no flag raised.
- R12: After reset, all counters, latches and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ch_pulse | input | NCH | One single-cycle edge pulse per channel |
| trig | input | 1 | Latch strobe for all channels |
| auto_rst | input | 1 | Clear counters with each trigger |
| aux_gate | input | 1 | Shared auxiliary gate level |
| aux_mode | input | 2 | Gate function: 00 inhibit, 01 reset, 10 test, 11 none |
| sw_clr | input | 1 | Clear all counters and latches |
| rd_addr | input | AW (12) | Byte address in the counter window |
| rd_data | output | CW (32) | Live counter value, registered |
| lat_flat | output | NCH*CW | All latches, channel N at bits N*CW upward |

## Verification
A counter that has slipped shows up at the read port one cycle after its address is presented. It also shows up on the latch bus one cycle after the next trigger, so every snapshot exposes the state of every channel. The bench runs a near-exhaustive sweep over gate modes, trigger, auto-reset and pulse patterns. After each step it compares all latches and one rotating read against an arithmetic model, so a wrong count, a missed capture or a wrong gate decode shows up within a few cycles of its cause.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
  typedef enum logic [1:0] {
    GATE_INHIBIT = 2'b00,
    GATE_CLEAR   = 2'b01,
    GATE_TEST    = 2'b10,
    GATE_NONE    = 2'b11
  } gate_mode_e;

  localparam int unsigned WIN_BASE = 32'h100;
endpackage

// File: rtl/scaler_gate_ctrl.sv
module scaler_gate_ctrl
  import scaler_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       aux_gate,
  input  logic [1:0] aux_mode,
  input  logic       sw_clr,
  output logic       cnt_block,
  output logic       test_inc,
  output logic       clr_all
);
  gate_mode_e mode;
  logic       clr_gate;

  always_comb begin
    mode      = gate_mode_e'(aux_mode);
    cnt_block = 1'b0;
    test_inc  = 1'b0;
    clr_gate  = 1'b0;
    if (aux_gate) begin
      case (mode)
        GATE_INHIBIT: cnt_block = 1'b1;
        GATE_CLEAR:   clr_gate  = 1'b1;
        GATE_TEST:    test_inc  = 1'b1;
        default:      ;
      endcase
    end
    clr_all = clr_gate | sw_clr;
  end

  // R3 R4 R5: at most one gate function is active in any cycle
  a_r5_gate_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_block, test_inc, clr_gate}));

  // R6: the reserved code drives no gate function
  a_r6_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_mode == 2'b11 && !sw_clr) |-> (!cnt_block && !test_inc && !clr_all));
endmodule

// File: rtl/scaler_chan.sv
module scaler_chan #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_in,
  input  logic          test_inc,
  input  logic          cnt_block,
  input  logic          trig,
  input  logic          auto_rst,
  input  logic          clr_all,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] lat_q
);
  logic          inc;
  logic          cnt_en;
  logic          lat_en;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] lat_d;

  always_comb begin
    inc    = !cnt_block && (edge_in || test_inc);
    cnt_en = clr_all || inc || (trig && auto_rst);
    lat_en = clr_all || trig;
    cnt_d  = cnt_q;
    lat_d  = lat_q;
    if (clr_all) begin
      cnt_d = '0;
      lat_d = '0;
    end else begin
      if (trig) lat_d = cnt_q;
      if (trig && auto_rst) cnt_d = {{(CW-1){1'b0}}, inc};
      else if (inc)         cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

  // R1 R11: a counted pulse advances by one, wrapping modulo 2**CW
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_in && !cnt_block && !clr_all && !(trig && auto_rst))
      |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3: inhibit freezes the counter
  a_r3_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_block && !clr_all && !trig) |=> $stable(cnt_q));

  // R2: capture takes the pre-edge count
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !clr_all) |=> lat_q == $past(cnt_q));

  // R2: latch holds without trigger
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !clr_all) |=> $stable(lat_q));

  // R7 R8: auto-reset leaves at most the coincident pulse
  a_r7_auto_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && auto_rst && !clr_all) |=> cnt_q <= CW'(1));

  // R4 R9: any clear empties counter and latch
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (cnt_q == '0 && lat_q == '0));
endmodule

// File: rtl/scaler_rdport.sv
module scaler_rdport
  import scaler_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 32,
  parameter int AW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr,
  input  logic [NCH*CW-1:0] cnt_flat,
  output logic [CW-1:0]     rd_data
);
  localparam int IW = AW - 2;

  logic [AW-1:0] off;
  logic [IW-1:0] idx;
  logic          hit;
  logic [CW-1:0] word;

  always_comb begin
    off  = rd_addr - AW'(WIN_BASE);
    idx  = off[AW-1:2];
    hit  = (rd_addr[1:0] == 2'b00) && (32'(rd_addr) >= WIN_BASE) && (32'(idx) < NCH);
    word = '0;
    for (int i = 0; i < NCH; i++) begin
      if (hit && idx == IW'(i)) word = cnt_flat[i*CW +: CW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= word;
  end

  // R10: unmapped addresses read zero
  a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[1:0] != 2'b00 || 32'(rd_addr) < WIN_BASE) |=> rd_data == '0);
endmodule

// File: rtl/scaler_bank.sv
module scaler_bank
  import scaler_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 32,
  parameter int AW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ch_pulse,
  input  logic              trig,
  input  logic              auto_rst,
  input  logic              aux_gate,
  input  logic [1:0]        aux_mode,
  input  logic              sw_clr,
  input  logic [AW-1:0]     rd_addr,
  output logic [CW-1:0]     rd_data,
  output logic [NCH*CW-1:0] lat_flat
);
  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic              cnt_block;
  logic              test_inc;
  logic              clr_all;
  logic [NCH*CW-1:0] cnt_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  scaler_gate_ctrl u_gate (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .aux_gate  (aux_gate),
    .aux_mode  (aux_mode),
    .sw_clr    (sw_clr),
    .cnt_block (cnt_block),
    .test_inc  (test_inc),
    .clr_all   (clr_all)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    scaler_chan #(.CW(CW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .edge_in   (ch_pulse[g]),
      .test_inc  (test_inc),
      .cnt_block (cnt_block),
      .trig      (trig),
      .auto_rst  (auto_rst),
      .clr_all   (clr_all),
      .cnt_q     (cnt_flat[g*CW +: CW]),
      .lat_q     (lat_flat[g*CW +: CW])
    );
  end

  scaler_rdport #(.NCH(NCH), .CW(CW), .AW(AW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rd_addr  (rd_addr),
    .cnt_flat (cnt_flat),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/scaler_bank_test.sv
module scaler_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;
  localparam int CW  = 6;
  localparam int AW  = 12;
  localparam int MASK = (1 << CW) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    ch_pulse;
  logic              trig, auto_rst, aux_gate, sw_clr;
  logic [1:0]        aux_mode;
  logic [AW-1:0]     rd_addr;
  logic [CW-1:0]     rd_data;
  logic [NCH*CW-1:0] lat_flat;

  int n_chk = 0;
  int n_bad = 0;
  int mcnt[NCH];
  int mlat[NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  scaler_bank #(.NCH(NCH), .CW(CW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ch_pulse(ch_pulse), .trig(trig),
    .auto_rst(auto_rst), .aux_gate(aux_gate), .aux_mode(aux_mode),
    .sw_clr(sw_clr), .rd_addr(rd_addr), .rd_data(rd_data), .lat_flat(lat_flat)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R10 window rule: 0x100 + 4*N, aligned, N < NCH, else 0
  function automatic int exp_read(input int a);
    if ((a % 4) != 0 || a < 'h100 || (a - 'h100) / 4 >= NCH) return 0;
    return mcnt[(a - 'h100) / 4];
  endfunction

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic [NCH-1:0] p, input logic t, input logic g,
                      input logic [1:0] m, input logic ar, input logic sc,
                      input int a, input string tag);
    int  exp_rd;
    logic blk, tst, clr;
    ch_pulse = p; trig = t; aux_gate = g; aux_mode = m;
    auto_rst = ar; sw_clr = sc; rd_addr = AW'(a);
    exp_rd = exp_read(a);
    blk = g && (m == 2'b00);
    tst = g && (m == 2'b10);
    clr = sc || (g && (m == 2'b01));
    @(posedge clk);
    for (int i = 0; i < NCH; i++) begin
      int inc;
      inc = (!blk && (p[i] || tst)) ? 1 : 0;
      if (clr) begin
        mcnt[i] = 0; mlat[i] = 0;
      end else begin
        if (t) mlat[i] = mcnt[i];
        if (t && ar) mcnt[i] = inc;
        else mcnt[i] = (mcnt[i] + inc) & MASK;
      end
    end
    @(negedge clk);
    for (int i = 0; i < NCH; i++)
      check({tag, " latch"}, int'(lat_flat[i*CW +: CW]), mlat[i]);
    check({tag, " read"}, int'(rd_data), exp_rd);
  endtask

  task automatic idle_read(input int ch, input string tag);
    step('0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 'h100 + 4*ch, tag);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < NCH; i++) idle_read(i, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin mcnt[i] = 0; mlat[i] = 0; end
    ch_pulse = '0; trig = 0; auto_rst = 0; aux_gate = 0; aux_mode = 2'b11;
    sw_clr = 0; rd_addr = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R12 reset state
    check("R12 rd_data", int'(rd_data), 0);
    read_all("R12 reset");

    // R1 plain counting
    step(5'b10101, 0, 0, 2'b11, 0, 0, 'h100, "R1 count");
    step(5'b11011, 0, 0, 2'b11, 0, 0, 'h104, "R1 count");
    step(5'b00110, 0, 0, 2'b11, 0, 0, 'h108, "R1 count");
    read_all("R1 totals");

    // R2 capture while counting
    step(5'b11111, 1, 0, 2'b11, 0, 0, 'h10C, "R2 capture");
    step(5'b01010, 0, 0, 2'b11, 0, 0, 'h110, "R2 hold");
    read_all("R2 continue");

    // R3 inhibit
    step(5'b11111, 0, 1, 2'b00, 0, 0, 'h100, "R3 inhibit");
    step(5'b11111, 1, 1, 2'b00, 0, 0, 'h104, "R3 inhibit trig");
    read_all("R3 frozen");

    // R5 test pulse, with overlapping own pulse
    step(5'b00011, 0, 1, 2'b10, 0, 0, 'h100, "R5 test");
    step(5'b00000, 0, 1, 2'b10, 0, 0, 'h104, "R5 test");
    read_all("R5 totals");

    // R6 reserved mode: gate ignored
    step(5'b10001, 0, 1, 2'b11, 0, 0, 'h100, "R6 reserved");
    step(5'b00000, 1, 1, 2'b11, 0, 0, 'h110, "R6 reserved trig");
    read_all("R6 totals");

    // R4 gate reset
    step(5'b11111, 1, 1, 2'b01, 0, 0, 'h100, "R4 gate reset");
    read_all("R4 cleared");

    // R7 auto-reset intervals
    step(5'b11100, 0, 0, 2'b11, 0, 0, 'h100, "R7 fill");
    step(5'b10100, 0, 0, 2'b11, 0, 0, 'h100, "R7 fill");
    step(5'b00000, 1, 0, 2'b11, 1, 0, 'h100, "R7 auto trig");
    step(5'b00001, 0, 0, 2'b11, 1, 0, 'h100, "R7 after");
    step(5'b00000, 1, 0, 2'b11, 1, 0, 'h110, "R7 interval");
    read_all("R7 zeroed");

    // R8 coincidence of auto-reset trigger and pulse
    step(5'b11111, 0, 0, 2'b11, 0, 0, 'h100, "R8 fill");
    step(5'b01111, 1, 0, 2'b11, 1, 0, 'h100, "R8 coincide");
    read_all("R8 restart");

    // R9 software clear beats trigger and pulses
    step(5'b11111, 0, 0, 2'b11, 0, 0, 'h100, "R9 fill");
    step(5'b11111, 1, 0, 2'b11, 0, 1, 'h100, "R9 clear");
    read_all("R9 cleared");

    // R10 address map
    step(5'b10110, 0, 0, 2'b11, 0, 0, 'h100, "R10 fill");
    step(5'b00000, 0, 0, 2'b11, 0, 0, 'h102, "R10 misaligned");
    step(5'b00000, 0, 0, 2'b11, 0, 0, 'h0FC, "R10 below");
    step(5'b00000, 0, 0, 2'b11, 0, 0, 'h100 + 4*NCH, "R10 past end");
    step(5'b00000, 0, 0, 2'b11, 0, 0, 'h000, "R10 zero");
    read_all("R10 map");

    // R11 wrap on channel 0
    for (int k = 0; k < (1 << CW) + 3; k++)
      step(5'b00001, 0, 0, 2'b11, 0, 0, 'h100, "R11 wrap");
    read_all("R11 wrapped");

    // near-exhaustive sweep over mode, gate, trig, auto-reset, patterns
    for (int k = 0; k < 1024; k++) begin
      logic [NCH-1:0] p;
      p = NCH'((k * 7) ^ (k >> 3));
      step(p, k[1], k[0], k[3:2], k[4], (k % 97) == 96,
           'h100 + 4*(k % (NCH + 1)), "R1 R3 R5 R6 R7 sweep");
    end
    read_all("R2 sweep end");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule